// File: doc/BRIEF.md
# Active-Matrix Panel Scan Timing Generator

This block drives the digital control pulses of a polysilicon active-matrix display panel that carries its own bidirectional horizontal and vertical shift registers. From one fast system clock it produces the horizontal start pulse, two complementary horizontal clocks, the vertical start pulse and clock, the gate enable, the precharge pulse and the black-frame pulse. It also produces a frame-start strobe and an active-line strobe that a downstream video pipeline can align to.

Each line has a video part and a blanking part. In the video part the horizontal clocks run for a set number of periods. The start pulse straddles the first sampling edge, and which edge that is depends on the right/left scan input. The blanking part follows a fixed order. Gate enable drops, then precharge rises. The vertical clock toggles while precharge is high, and gate enable returns only after that toggle. A frame opens with black-frame lines and a gap line. The vertical start pulse comes next, and then the panel rows. In short mode the unused rows are split evenly above and below the picture and are written black, so the picture stays centred. The mode and direction inputs are captured once per frame.

Top module: `scan_timing_gen`

## Requirements
- R1: While reset is held, every output is low, except that hck2_o is high and vck_o rests at the level a down-scan frame starts with (high when BLK_LINES is even).
- R2: Within each line, cycle 0 is the start of the line and video starts at cycle HCK_HALF. From there hck1_o runs H_ACT periods of 2*HCK_HALF cycles, high for the first half of each period. hck2_o is always its complement. Outside video, hck1_o is low and hck2_o is high.
- R3: With right_scan_i high, hst_o is high for 2*HST_M cycles centred on the first hck1_o rising edge of the line.
- R4: With right_scan_i low, the hst_o window moves HCK_HALF cycles later, so that it is centred on the first hck2_o rising edge.
- R5: Let E be the first cycle after video ends. enb_o is low for cycles E+ENB_FALL up to E+ENB_FALL+PCG_GAP+VCK_GAP+ENB_GAP-1. The generated precharge is high for PCG_W cycles starting at E+ENB_FALL+PCG_GAP. vck_o toggles at cycle E+ENB_FALL+PCG_GAP+VCK_GAP.
- R6: pcg_o is high whenever blk_o is high, in addition to the generated precharge window.
- R7: blk_o is high for frame lines 0 to BLK_LINES-1. vst_o is high only in line BLK_LINES+1, for VST_M cycles before and VST_M cycles from the vck_o toggle of that line.
- R8: vck_o toggles exactly once per line. With down_scan_i high, the toggle under vst_o is a rising edge. With it low, that toggle is a falling edge.
- R9: Panel rows occupy lines BLK_LINES+2 onward, V_FULL of them. In full mode (full_mode_i high) all rows are active. In short mode only the middle V_SHORT rows are active, and the (V_FULL-V_SHORT)/2 rows on each side hold blk_o high for the whole line.
- R10: frame_o is high for one cycle, at cycle 0 of line 0. line_o is high for one cycle, at cycle 0 of each active line.
- R11: The mode and direction inputs are captured on the last cycle of a frame and apply to the whole next frame. A change in the middle of a frame has no effect on that frame. The first frame after reset uses full mode, right scan and down scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| full_mode_i | input | 1 | 1: all V_FULL rows active, 0: V_SHORT centred rows |
| right_scan_i | input | 1 | 1: right scan, 0: left scan |
| down_scan_i | input | 1 | 1: down scan, 0: up scan |
| hst_o | output | 1 | Horizontal start pulse |
| hck1_o | output | 1 | Horizontal clock, first phase |
| hck2_o | output | 1 | Horizontal clock, complementary phase |
| vst_o | output | 1 | Vertical start pulse |
| vck_o | output | 1 | Vertical clock, both edges active |
| enb_o | output | 1 | Gate enable |
| pcg_o | output | 1 | Precharge pulse ORed with black-frame pulse |
| blk_o | output | 1 | Black-frame pulse |
| frame_o | output | 1 | Frame-start strobe |
| line_o | output | 1 | Active-line start strobe |

## Verification
The assertions assume that the cycle parameters place every blanking event inside one line: the precharge window contains the vertical-clock toggle and ends before gate enable returns. They also assume that V_TOTAL is even, so that the vertical clock keeps its edge sense across frames. A frame-start edge of vck_o after a change of up/down direction is exempted. The stimulus keeps a small, consistent parameter set and changes the mode and direction inputs only between clock edges, some of them in the middle of a frame, to exercise the capture at frame end.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef struct packed {
    logic full;
    logic rgt;
    logic dwn;
  } scan_cfg_t;

  localparam scan_cfg_t CFG_RESET = '{full: 1'b1, rgt: 1'b1, dwn: 1'b1};

  typedef struct packed {
    logic hst;
    logic hck1;
    logic hck2;
    logic vst;
    logic vck;
    logic enb;
    logic pcg;
    logic blk;
    logic frame;
    logic line;
  } scan_out_t;

endpackage

// File: rtl/scan_hgen.sv
module scan_hgen #(
  parameter int HCK_HALF = 4,
  parameter int H_ACT    = 134,
  parameter int H_BLANK  = 112,
  parameter int ENB_FALL = 32,
  parameter int PCG_GAP  = 23,
  parameter int PCG_W    = 39,
  parameter int VCK_GAP  = 32,
  parameter int ENB_GAP  = 16,
  parameter int HST_M    = 2,
  parameter int VST_M    = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rgt_i,
  output logic line_first_o,
  output logic line_last_o,
  output logic hck1_o,
  output logic hst_o,
  output logic enb_o,
  output logic pcg_o,
  output logic vck_past_o,
  output logic vst_win_o
);

  localparam int HCK_PER   = 2 * HCK_HALF;
  localparam int VID_START = HCK_HALF;
  localparam int VID_END   = VID_START + H_ACT * HCK_PER;
  localparam int T_EF      = VID_END + ENB_FALL;
  localparam int T_PR      = T_EF + PCG_GAP;
  localparam int T_PF      = T_PR + PCG_W;
  localparam int T_VT      = T_PR + VCK_GAP;
  localparam int T_ER      = T_VT + ENB_GAP;
  localparam int LINE_CYC  = VID_END + H_BLANK;
  localparam int HW        = $clog2(LINE_CYC + 1);
  localparam int PHW       = $clog2(HCK_PER);

  localparam logic [HW-1:0]  LAST_C  = HW'(LINE_CYC - 1);
  localparam logic [HW-1:0]  PRE_C   = HW'(VID_START - 1);
  localparam logic [HW-1:0]  VS_C    = HW'(VID_START);
  localparam logic [HW-1:0]  VE_C    = HW'(VID_END);
  localparam logic [HW-1:0]  HR_LO_C = HW'(VID_START - HST_M);
  localparam logic [HW-1:0]  HR_HI_C = HW'(VID_START + HST_M);
  localparam logic [HW-1:0]  HL_LO_C = HW'(VID_START + HCK_HALF - HST_M);
  localparam logic [HW-1:0]  HL_HI_C = HW'(VID_START + HCK_HALF + HST_M);
  localparam logic [HW-1:0]  EF_C    = HW'(T_EF);
  localparam logic [HW-1:0]  ER_C    = HW'(T_ER);
  localparam logic [HW-1:0]  PR_C    = HW'(T_PR);
  localparam logic [HW-1:0]  PF_C    = HW'(T_PF);
  localparam logic [HW-1:0]  VT_C    = HW'(T_VT);
  localparam logic [HW-1:0]  SL_C    = HW'(T_VT - VST_M);
  localparam logic [HW-1:0]  SH_C    = HW'(T_VT + VST_M);
  localparam logic [PHW-1:0] PH_LAST_C = PHW'(HCK_PER - 1);
  localparam logic [PHW-1:0] HALF_C    = PHW'(HCK_HALF);

  logic [HW-1:0]  hcnt_q, hcnt_d;
  logic [PHW-1:0] ph_q, ph_d;
  logic           in_vid;

  // next state
  always_comb begin
    line_last_o = (hcnt_q == LAST_C);
    hcnt_d      = line_last_o ? '0 : hcnt_q + 1'b1;
    if (hcnt_q == PRE_C || ph_q == PH_LAST_C) ph_d = '0;
    else                                      ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      ph_q   <= '0;
    end else begin
      hcnt_q <= hcnt_d;
      ph_q   <= ph_d;
    end
  end

  // position decode
  always_comb begin
    line_first_o = (hcnt_q == '0);
    in_vid       = (hcnt_q >= VS_C) && (hcnt_q < VE_C);
    hck1_o       = in_vid && (ph_q < HALF_C);
    if (rgt_i) hst_o = (hcnt_q >= HR_LO_C) && (hcnt_q < HR_HI_C);
    else       hst_o = (hcnt_q >= HL_LO_C) && (hcnt_q < HL_HI_C);
    enb_o        = !((hcnt_q >= EF_C) && (hcnt_q < ER_C));
    pcg_o        = (hcnt_q >= PR_C) && (hcnt_q < PF_C);
    vck_past_o   = (hcnt_q >= VT_C);
    vst_win_o    = (hcnt_q >= SL_C) && (hcnt_q < SH_C);
  end

endmodule

// File: rtl/scan_vgen.sv
module scan_vgen
  import scan_pkg::*;
#(
  parameter int V_FULL    = 604,
  parameter int V_SHORT   = 500,
  parameter int V_TOTAL   = 628,
  parameter int BLK_LINES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      line_last_i,
  input  logic      vck_past_i,
  input  scan_cfg_t cfg_i,
  output logic      rgt_o,
  output logic      frame_top_o,
  output logic      vst_line_o,
  output logic      blk_o,
  output logic      vck_o,
  output logic      act_o
);

  localparam int VSTL = BLK_LINES + 1;
  localparam int ROW0 = VSTL + 1;
  localparam int OFF  = (V_FULL - V_SHORT) / 2;
  localparam int VW   = $clog2(V_TOTAL + 1);

  localparam logic [VW-1:0] VLAST_C  = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] BLK_C    = VW'(BLK_LINES);
  localparam logic [VW-1:0] VSTL_C   = VW'(VSTL);
  localparam logic [VW-1:0] R_LO_C   = VW'(ROW0);
  localparam logic [VW-1:0] R_HI_C   = VW'(ROW0 + V_FULL);
  localparam logic [VW-1:0] A_LO_C   = VW'(ROW0 + OFF);
  localparam logic [VW-1:0] A_HI_C   = VW'(ROW0 + OFF + V_SHORT);
  localparam logic          VST_PAR  = 1'(VSTL % 2);

  logic [VW-1:0] vcnt_q, vcnt_d;
  scan_cfg_t     cfg_q, cfg_d;
  logic          frame_last, in_rows;

  // next state: line counter and per-frame configuration
  always_comb begin
    frame_last = line_last_i && (vcnt_q == VLAST_C);
    vcnt_d     = vcnt_q;
    cfg_d      = cfg_q;
    if (line_last_i) vcnt_d = frame_last ? '0 : vcnt_q + 1'b1;
    if (frame_last)  cfg_d  = cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vcnt_q <= '0;
      cfg_q  <= CFG_RESET;
    end else begin
      vcnt_q <= vcnt_d;
      cfg_q  <= cfg_d;
    end
  end

  // line decode
  always_comb begin
    rgt_o       = cfg_q.rgt;
    frame_top_o = (vcnt_q == '0);
    vst_line_o  = (vcnt_q == VSTL_C);
    in_rows     = (vcnt_q >= R_LO_C) && (vcnt_q < R_HI_C);
    if (cfg_q.full) act_o = in_rows;
    else            act_o = (vcnt_q >= A_LO_C) && (vcnt_q < A_HI_C);
    blk_o       = (vcnt_q < BLK_C) || (in_rows && !act_o);
    // level follows toggle-count parity; edge sense under the start pulse set by direction
    vck_o       = vcnt_q[0] ^ vck_past_i ^ VST_PAR ^ ~cfg_q.dwn;
  end

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import scan_pkg::*;
#(
  parameter int HCK_HALF  = 4,
  parameter int H_ACT     = 134,
  parameter int H_BLANK   = 112,
  parameter int ENB_FALL  = 32,
  parameter int PCG_GAP   = 23,
  parameter int PCG_W     = 39,
  parameter int VCK_GAP   = 32,
  parameter int ENB_GAP   = 16,
  parameter int HST_M     = 2,
  parameter int VST_M     = 1,
  parameter int V_FULL    = 604,
  parameter int V_SHORT   = 500,
  parameter int V_TOTAL   = 628,
  parameter int BLK_LINES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_mode_i,
  input  logic right_scan_i,
  input  logic down_scan_i,
  output logic hst_o,
  output logic hck1_o,
  output logic hck2_o,
  output logic vst_o,
  output logic vck_o,
  output logic enb_o,
  output logic pcg_o,
  output logic blk_o,
  output logic frame_o,
  output logic line_o
);

  localparam logic VCK_RST = 1'((BLK_LINES + 1) % 2);

  logic [1:0] rs_q;
  logic       rst_n;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  scan_cfg_t cfg_pins;
  logic rgt, line_first, line_last, hck1_d, hst_d, enb_d, pcg_d, vck_past, vst_win;
  logic frame_top, vst_line, blk_d, vck_d, act_d;

  assign cfg_pins = '{full: full_mode_i, rgt: right_scan_i, dwn: down_scan_i};

  scan_hgen #(
    .HCK_HALF(HCK_HALF), .H_ACT(H_ACT), .H_BLANK(H_BLANK), .ENB_FALL(ENB_FALL),
    .PCG_GAP(PCG_GAP), .PCG_W(PCG_W), .VCK_GAP(VCK_GAP), .ENB_GAP(ENB_GAP),
    .HST_M(HST_M), .VST_M(VST_M)
  ) u_h (
    .clk_i(clk_i), .rst_ni(rst_n), .rgt_i(rgt),
    .line_first_o(line_first), .line_last_o(line_last), .hck1_o(hck1_d),
    .hst_o(hst_d), .enb_o(enb_d), .pcg_o(pcg_d), .vck_past_o(vck_past),
    .vst_win_o(vst_win)
  );

  scan_vgen #(
    .V_FULL(V_FULL), .V_SHORT(V_SHORT), .V_TOTAL(V_TOTAL), .BLK_LINES(BLK_LINES)
  ) u_v (
    .clk_i(clk_i), .rst_ni(rst_n), .line_last_i(line_last), .vck_past_i(vck_past),
    .cfg_i(cfg_pins), .rgt_o(rgt), .frame_top_o(frame_top), .vst_line_o(vst_line),
    .blk_o(blk_d), .vck_o(vck_d), .act_o(act_d)
  );

  scan_out_t out_d, out_q;

  always_comb begin
    out_d.hst   = hst_d;
    out_d.hck1  = hck1_d;
    out_d.hck2  = ~hck1_d;
    out_d.vst   = vst_line && vst_win;
    out_d.vck   = vck_d;
    out_d.enb   = enb_d;
    out_d.pcg   = pcg_d | blk_d;
    out_d.blk   = blk_d;
    out_d.frame = line_first && frame_top;
    out_d.line  = line_first && act_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      out_q      <= '0;
      out_q.hck2 <= 1'b1;
      out_q.vck  <= VCK_RST;
    end else begin
      out_q <= out_d;
    end
  end

  assign hst_o   = out_q.hst;
  assign hck1_o  = out_q.hck1;
  assign hck2_o  = out_q.hck2;
  assign vst_o   = out_q.vst;
  assign vck_o   = out_q.vck;
  assign enb_o   = out_q.enb;
  assign pcg_o   = out_q.pcg;
  assign blk_o   = out_q.blk;
  assign frame_o = out_q.frame;
  assign line_o  = out_q.line;

endmodule

// File: rtl/scan_timing_chk.sv
module scan_timing_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic hst_o,
  input logic hck1_o,
  input logic hck2_o,
  input logic vst_o,
  input logic vck_o,
  input logic enb_o,
  input logic pcg_o,
  input logic blk_o,
  input logic frame_o,
  input logic line_o
);

  AST_HCK_QUIET_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enb_o |-> (!hck1_o && hck2_o && !hst_o)); // R2
  AST_PCG_ENB_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcg_o && !blk_o) |-> !enb_o); // R5
  AST_VCK_IN_PCG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vck_o != $past(vck_o)) && !frame_o) |-> (!enb_o && pcg_o)); // R5
  AST_VST_IN_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vst_o |-> (!enb_o && !blk_o)); // R7
  AST_FRAME_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o); // R10
  AST_LINE_NOT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o |-> (!frame_o && !blk_o)); // R10

endmodule

bind scan_timing_gen scan_timing_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hst_o(hst_o), .hck1_o(hck1_o), .hck2_o(hck2_o),
  .vst_o(vst_o), .vck_o(vck_o), .enb_o(enb_o), .pcg_o(pcg_o), .blk_o(blk_o),
  .frame_o(frame_o), .line_o(line_o)
);

// File: tb/sim_scan_timing_gen.sv
module sim_scan_timing_gen;

  // small geometry: line = 4 + 6*8 + 112 = 164 cycles, frame = 14 lines
  localparam int NV = 58;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic full_i = 1'b1, rgt_i = 1'b1, dwn_i = 1'b1;
  logic hst_o, hck1_o, hck2_o, vst_o, vck_o, enb_o, pcg_o, blk_o, frame_o, line_o;

  int errors = 0;
  int checks = 0;
  int pos = 0;
  bit synced = 0;
  bit done = 0;
  logic [2:0] cur = 3'b111;

  always #10 clk = ~clk;

  scan_timing_gen #(.H_ACT(6), .V_FULL(8), .V_SHORT(4), .V_TOTAL(14)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .full_mode_i(full_i), .right_scan_i(rgt_i),
    .down_scan_i(dwn_i), .hst_o(hst_o), .hck1_o(hck1_o), .hck2_o(hck2_o),
    .vst_o(vst_o), .vck_o(vck_o), .enb_o(enb_o), .pcg_o(pcg_o), .blk_o(blk_o),
    .frame_o(frame_o), .line_o(line_o)
  );

  // {cfg{full,rgt,dwn}, line, cycle, signal, expected, requirement}
  // signal: 0 hst 1 hck1 2 hck2 3 vst 4 vck 5 enb 6 pcg 7 blk 8 frame 9 line
  localparam logic [27:0] VEC [NV] = '{
    {3'b111, 8'd0,  8'd0,   4'd8, 1'b1, 4'd10}, // R10 frame strobe
    {3'b111, 8'd0,  8'd1,   4'd8, 1'b0, 4'd10}, // R10 one cycle
    {3'b111, 8'd0,  8'd5,   4'd7, 1'b1, 4'd7},  // R7 black lines
    {3'b111, 8'd0,  8'd5,   4'd6, 1'b1, 4'd6},  // R6 OR into precharge
    {3'b111, 8'd1,  8'd163, 4'd7, 1'b1, 4'd7},  // R7
    {3'b111, 8'd2,  8'd0,   4'd7, 1'b0, 4'd7},  // R7 black ends
    {3'b111, 8'd2,  8'd1,   4'd0, 1'b0, 4'd3},  // R3
    {3'b111, 8'd2,  8'd2,   4'd0, 1'b1, 4'd3},  // R3
    {3'b111, 8'd2,  8'd3,   4'd1, 1'b0, 4'd2},  // R2
    {3'b111, 8'd2,  8'd3,   4'd2, 1'b1, 4'd2},  // R2
    {3'b111, 8'd2,  8'd4,   4'd1, 1'b1, 4'd2},  // R2 first rise
    {3'b111, 8'd2,  8'd5,   4'd0, 1'b1, 4'd3},  // R3
    {3'b111, 8'd2,  8'd6,   4'd0, 1'b0, 4'd3},  // R3
    {3'b111, 8'd2,  8'd7,   4'd1, 1'b1, 4'd2},  // R2
    {3'b111, 8'd2,  8'd8,   4'd1, 1'b0, 4'd2},  // R2
    {3'b111, 8'd2,  8'd8,   4'd2, 1'b1, 4'd2},  // R2
    {3'b111, 8'd2,  8'd47,  4'd1, 1'b1, 4'd2},  // R2 last period
    {3'b111, 8'd2,  8'd51,  4'd1, 1'b0, 4'd2},  // R2
    {3'b111, 8'd2,  8'd52,  4'd1, 1'b0, 4'd2},  // R2 idle
    {3'b111, 8'd2,  8'd52,  4'd2, 1'b1, 4'd2},  // R2
    {3'b111, 8'd2,  8'd83,  4'd5, 1'b1, 4'd5},  // R5
    {3'b111, 8'd2,  8'd84,  4'd5, 1'b0, 4'd5},  // R5 enable falls
    {3'b111, 8'd2,  8'd106, 4'd6, 1'b0, 4'd5},  // R5
    {3'b111, 8'd2,  8'd107, 4'd6, 1'b1, 4'd5},  // R5 precharge rises
    {3'b111, 8'd2,  8'd138, 4'd4, 1'b1, 4'd5},  // R5
    {3'b111, 8'd2,  8'd139, 4'd4, 1'b0, 4'd5},  // R5 vck toggles
    {3'b111, 8'd2,  8'd145, 4'd6, 1'b1, 4'd5},  // R5
    {3'b111, 8'd2,  8'd146, 4'd6, 1'b0, 4'd5},  // R5 width 39
    {3'b111, 8'd2,  8'd154, 4'd5, 1'b0, 4'd5},  // R5
    {3'b111, 8'd2,  8'd155, 4'd5, 1'b1, 4'd5},  // R5 enable returns
    {3'b111, 8'd3,  8'd0,   4'd9, 1'b0, 4'd9},  // R9
    {3'b111, 8'd3,  8'd137, 4'd3, 1'b0, 4'd7},  // R7
    {3'b111, 8'd3,  8'd138, 4'd3, 1'b1, 4'd7},  // R7 start pulse
    {3'b111, 8'd3,  8'd138, 4'd4, 1'b0, 4'd8},  // R8
    {3'b111, 8'd3,  8'd139, 4'd3, 1'b1, 4'd7},  // R7
    {3'b111, 8'd3,  8'd139, 4'd4, 1'b1, 4'd8},  // R8 rising in down scan
    {3'b111, 8'd3,  8'd140, 4'd3, 1'b0, 4'd7},  // R7
    {3'b111, 8'd4,  8'd0,   4'd9, 1'b1, 4'd9},  // R9 first row active
    {3'b111, 8'd4,  8'd1,   4'd9, 1'b0, 4'd10}, // R10
    {3'b111, 8'd4,  8'd10,  4'd7, 1'b0, 4'd9},  // R9
    {3'b111, 8'd11, 8'd0,   4'd9, 1'b1, 4'd9},  // R9 last row
    {3'b111, 8'd12, 8'd0,   4'd9, 1'b0, 4'd9},  // R9
    {3'b011, 8'd4,  8'd0,   4'd9, 1'b0, 4'd9},  // R9 short: border row
    {3'b011, 8'd4,  8'd0,   4'd7, 1'b1, 4'd9},  // R9
    {3'b011, 8'd4,  8'd10,  4'd6, 1'b1, 4'd6},  // R6
    {3'b011, 8'd5,  8'd100, 4'd7, 1'b1, 4'd9},  // R9
    {3'b011, 8'd6,  8'd0,   4'd9, 1'b1, 4'd9},  // R9 centred start
    {3'b011, 8'd6,  8'd0,   4'd7, 1'b0, 4'd9},  // R9
    {3'b011, 8'd9,  8'd0,   4'd9, 1'b1, 4'd9},  // R9
    {3'b011, 8'd10, 8'd0,   4'd9, 1'b0, 4'd9},  // R9
    {3'b011, 8'd10, 8'd0,   4'd7, 1'b1, 4'd9},  // R9 lower border
    {3'b011, 8'd12, 8'd0,   4'd7, 1'b0, 4'd9},  // R9
    {3'b101, 8'd2,  8'd5,   4'd0, 1'b0, 4'd4},  // R4 left scan
    {3'b101, 8'd2,  8'd6,   4'd0, 1'b1, 4'd4},  // R4
    {3'b101, 8'd2,  8'd9,   4'd0, 1'b1, 4'd4},  // R4
    {3'b101, 8'd2,  8'd10,  4'd0, 1'b0, 4'd4},  // R4
    {3'b110, 8'd3,  8'd138, 4'd4, 1'b1, 4'd8},  // R8 up scan
    {3'b110, 8'd3,  8'd139, 4'd4, 1'b0, 4'd8}   // R8 falling edge
  };

  function automatic logic pick(input int s);
    case (s)
      0: return hst_o;   1: return hck1_o;  2: return hck2_o;
      3: return vst_o;   4: return vck_o;   5: return enb_o;
      6: return pcg_o;   7: return blk_o;   8: return frame_o;
      default: return line_o;
    endcase
  endfunction

  task automatic chk(input int ln, input int cy, input int s, input logic e, input int r);
    checks++;
    if (pick(s) !== e) begin
      errors++;
      $display("FAIL R%0d line %0d cyc %0d sig %0d: got %b expected %b", r, ln, cy, s, pick(s), e);
    end
  endtask

  // move to a frame position under a configuration; resync at a new frame when needed
  task automatic go(input logic [2:0] c, input int tgt);
    if (!synced || c != cur || tgt < pos) begin
      {full_i, rgt_i, dwn_i} = c;
      cur = c;
      @(negedge clk);
      do @(negedge clk); while (!frame_o);
      pos = 0;
      synced = 1;
    end
    while (pos < tgt) begin
      @(negedge clk);
      pos++;
    end
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(0, 0, 0, 1'b0, 1); chk(0, 0, 1, 1'b0, 1); chk(0, 0, 2, 1'b1, 1);
    chk(0, 0, 4, 1'b1, 1); chk(0, 0, 5, 1'b0, 1); chk(0, 0, 6, 1'b0, 1);
    chk(0, 0, 8, 1'b0, 1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      go(VEC[i][27:25], int'(VEC[i][24:17]) * 164 + int'(VEC[i][16:9]));
      chk(int'(VEC[i][24:17]), int'(VEC[i][16:9]), int'(VEC[i][8:5]), VEC[i][4], int'(VEC[i][3:0]));
    end

    // R11 mid-frame change has no effect on the current frame
    go(3'b111, 164);
    full_i = 1'b0;
    rgt_i  = 1'b0;
    go(3'b111, 2 * 164 + 2);
    chk(2, 2, 0, 1'b1, 11);
    go(3'b111, 4 * 164);
    chk(4, 0, 9, 1'b1, 11);
    // R11 next frame picks up the new inputs
    go(3'b001, 2 * 164 + 6);
    chk(2, 6, 0, 1'b1, 11);
    go(3'b001, 4 * 164);
    chk(4, 0, 9, 1'b0, 11);
    chk(4, 0, 7, 1'b1, 11);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule